// File: doc/BRIEF.md
# Multi-Step ADC Conversion Sequencer

This block sits in front of a successive-approximation converter. It works through a table of up to sixteen programmable conversion steps. Each step routes one of eight analog input lines to the converter through a mux select. It then waits an open delay and a sample delay, both counted in clock cycles, and requests one or more conversions. The block averages a power-of-two number of samples and emits the mean. Each result carries the number of the step that produced it, so a downstream result FIFO can tell the channels apart.

Software programs the step table, a step-enable mask and a module enable through a small register port. Each trigger on `start` runs one pass over the enabled steps in ascending order. A step programmed for continuous operation keeps the sequencer looping without further triggers. In one-shot operation the mask clears itself once the pass is done. When the module is disabled, a conversion that is already under way is allowed to finish before the sequencer parks. The analog front end, the converter itself and the result FIFO all sit outside this block.

Top module: `adc_step_seq`

## Requirements
- R1: Register map, addressed by `cfg_addr`, with read data on `cfg_rdata` one cycle after the address is presented:
  - 0x00 holds the module enable in bit 0.
  - 0x01 holds the 17-bit step-enable mask.
  - 0x02 is the read-only status word.
  - 0x10+n configures step n: bits [2:0] select the input line, bits [6:4] hold the averaging code, and bit 8 selects continuous mode.
  - 0x20+n holds the delays of step n: the open delay in bits [17:0] and the sample delay in bits [31:24].
- R2: A one-cycle `start` launches a pass only when the module is enabled and at least one step is enabled. Step n is enabled by mask bit n+1. Mask bit 0 is reserved for the charge step and never launches a conversion. `start` is ignored while the module is disabled.
- R3: Enabled steps run in ascending step order, and disabled steps are skipped without spending a cycle. `mux_sel` carries the configured input line of the running step for every conversion that step makes.
- R4: Take the clock edge that samples `start` as edge 1. `conv_req` for the first step is first seen high after edge open+sample+1. A delay value of 0 adds no wait.
- R5: A step with averaging code c performs 2^c conversions, waiting the sample delay before each one. Its result is the sum of those samples shifted right by c. Codes 5 to 7 behave as code 4 (16 samples).
- R6: Each finished step raises `res_valid` for one cycle. `res_step` then holds the 4-bit step number and `res_data` holds the 12-bit averaged value.
- R7: In one-shot mode, once the last enabled step has delivered its result, the mask reads 0 and the sequencer is idle.
- R8: If the last enabled step of a pass has its continuous bit set, the sequencer wraps to the lowest enabled step without a new `start` and leaves the mask unchanged.
- R9: Clearing the module enable during a delay returns the sequencer to idle at once, with no further request. Clearing it during a conversion holds `conv_req` until `conv_done` arrives, discards that sample, and then goes idle.
- R10: The status word reads 0x10 when the sequencer is idle. While it is busy it reads 0x20 plus the number of the running step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |
| start | input | 1 | Trigger that launches one pass |
| conv_done | input | 1 | One-cycle pulse from the converter when a sample is ready |
| conv_data | input | 12 | Converter sample, valid with `conv_done` |
| mux_sel | output | 3 | Analog input line routed to the converter |
| conv_req | output | 1 | Conversion request, held high until `conv_done` |
| res_valid | output | 1 | One-cycle strobe for a finished step result |
| res_step | output | 4 | Step number of the result |
| res_data | output | 12 | Averaged result value |

## Verification
The hardest state to reach from the ports is a disable that lands while a conversion is still pending. The bench gets there with a single zero-delay step and a converter stub whose latency is fixed and known. It waits for `conv_req` to rise and then writes the enable off. This places the write inside the stub's countdown, so the bench can watch the request stay high, then drop, with no result emitted. Continuous wrap and the mask clear at the end of a one-shot pass are reached in the same way: the bench programs the continuous bit only on the highest enabled step and compares the ordered stream of tagged results against a model of the scan.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPEN,
    S_SAMP,
    S_CONV,
    S_DRAIN
  } seq_state_e;

  localparam int ADDR_W = 6;
  localparam int REG_W  = 32;

  localparam logic [ADDR_W-1:0] A_CTRL     = 6'h00;
  localparam logic [ADDR_W-1:0] A_MASK     = 6'h01;
  localparam logic [ADDR_W-1:0] A_STAT     = 6'h02;
  localparam logic [1:0]        A_CFG_PAGE = 2'b01;
  localparam logic [1:0]        A_DLY_PAGE = 2'b10;

  localparam logic [REG_W-1:0] STAT_IDLE = 32'h10;
  localparam logic [REG_W-1:0] STAT_BUSY = 32'h20;

  localparam int CFG_AVG_LSB  = 4;
  localparam int CFG_CONT_BIT = 8;
  localparam int DLY_SMP_LSB  = 24;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int N_STEPS = 16,
  parameter int N_LINES = 8,
  parameter int OPEN_W  = 18,
  parameter int SAMP_W  = 8,
  parameter int AVG_W   = 3,
  localparam int STEP_W = $clog2(N_STEPS),
  localparam int SEL_W  = $clog2(N_LINES),
  localparam int MASK_W = N_STEPS + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              mask_clr,
  input  logic              busy,
  input  logic [STEP_W-1:0] cur_step,
  output logic              mod_en,
  output logic [MASK_W-1:0] mask,
  output logic [SEL_W-1:0]  line_a [N_STEPS],
  output logic [AVG_W-1:0]  avg_a  [N_STEPS],
  output logic              cont_a [N_STEPS],
  output logic [OPEN_W-1:0] open_a [N_STEPS],
  output logic [SAMP_W-1:0] samp_a [N_STEPS]
);

  logic             mask_wr;
  logic [REG_W-1:0] rd_word;
  logic [STEP_W-1:0] ridx;
  logic             unused_wbits;

  assign mask_wr      = we && (addr == A_MASK);
  assign ridx         = addr[STEP_W-1:0];
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_en <= 1'b0;
      mask   <= '0;
    end else begin
      if (we && addr == A_CTRL) mod_en <= wdata[0];
      if (mask_clr)             mask   <= '0;
      if (mask_wr)              mask   <= wdata[MASK_W-1:0];
    end
  end

  for (genvar g = 0; g < N_STEPS; g++) begin : g_step
    localparam logic [ADDR_W-1:0] CFG_A = {A_CFG_PAGE, 4'(g)};
    localparam logic [ADDR_W-1:0] DLY_A = {A_DLY_PAGE, 4'(g)};
    always_ff @(posedge clk) begin
      if (rst) begin
        line_a[g] <= '0;
        avg_a[g]  <= '0;
        cont_a[g] <= 1'b0;
        open_a[g] <= '0;
        samp_a[g] <= '0;
      end else if (we) begin
        if (addr == CFG_A) begin
          line_a[g] <= wdata[SEL_W-1:0];
          avg_a[g]  <= wdata[CFG_AVG_LSB +: AVG_W];
          cont_a[g] <= wdata[CFG_CONT_BIT];
        end
        if (addr == DLY_A) begin
          open_a[g] <= wdata[OPEN_W-1:0];
          samp_a[g] <= wdata[DLY_SMP_LSB +: SAMP_W];
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (addr == A_CTRL) begin
      rd_word[0] = mod_en;
    end else if (addr == A_MASK) begin
      rd_word[MASK_W-1:0] = mask;
    end else if (addr == A_STAT) begin
      rd_word = busy ? (STAT_BUSY | REG_W'(cur_step)) : STAT_IDLE;
    end else if (addr[5:4] == A_CFG_PAGE && int'(addr[3:0]) < N_STEPS) begin
      rd_word[SEL_W-1:0]              = line_a[ridx];
      rd_word[CFG_AVG_LSB +: AVG_W]   = avg_a[ridx];
      rd_word[CFG_CONT_BIT]           = cont_a[ridx];
    end else if (addr[5:4] == A_DLY_PAGE && int'(addr[3:0]) < N_STEPS) begin
      rd_word[OPEN_W-1:0]             = open_a[ridx];
      rd_word[DLY_SMP_LSB +: SAMP_W]  = samp_a[ridx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_word;
  end

  // R7
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_clr && !mask_wr) |=> (mask == '0));

endmodule

// File: rtl/adc_seq_acc.sv
module adc_seq_acc #(
  parameter int DATA_W  = 12,
  parameter int AVG_W   = 3,
  parameter int MAX_AVG = 4,
  parameter int STEP_W  = 4,
  localparam int ACC_W  = DATA_W + MAX_AVG,
  localparam int CNT_W  = MAX_AVG + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              add,
  input  logic [DATA_W-1:0] data,
  input  logic [AVG_W-1:0]  avg,
  input  logic [STEP_W-1:0] step,
  output logic              last,
  output logic              res_valid,
  output logic [STEP_W-1:0] res_step,
  output logic [DATA_W-1:0] res_data
);

  logic [ACC_W-1:0] sum_q, sum_nx, mean;
  logic [CNT_W-1:0] cnt_q, need;

  assign need   = CNT_W'(1) << avg;
  assign last   = (cnt_q + CNT_W'(1)) == need;
  assign sum_nx = sum_q + ACC_W'(data);
  assign mean   = sum_nx >> avg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q     <= '0;
      cnt_q     <= '0;
      res_valid <= 1'b0;
      res_step  <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (add) begin
        if (last) begin
          res_valid <= 1'b1;
          res_step  <= step;
          res_data  <= mean[DATA_W-1:0];
          sum_q     <= '0;
          cnt_q     <= '0;
        end else begin
          sum_q <= sum_nx;
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end else if (clr) begin
        sum_q <= '0;
        cnt_q <= '0;
      end
    end
  end

  // R6
  result_after_conv_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(add));

  // R5
  smp_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(1 << MAX_AVG));

endmodule

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
  import adc_seq_pkg::*;
#(
  parameter int N_STEPS = 16,
  parameter int N_LINES = 8,
  parameter int OPEN_W  = 18,
  parameter int SAMP_W  = 8,
  parameter int AVG_W   = 3,
  parameter int MAX_AVG = 4,
  localparam int STEP_W = $clog2(N_STEPS),
  localparam int SEL_W  = $clog2(N_LINES),
  localparam int MASK_W = N_STEPS + 1,
  localparam int CNT_W  = (OPEN_W > SAMP_W) ? OPEN_W : SAMP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mod_en,
  input  logic              start,
  input  logic [MASK_W-1:0] mask,
  input  logic [SEL_W-1:0]  line_a [N_STEPS],
  input  logic [AVG_W-1:0]  avg_a  [N_STEPS],
  input  logic              cont_a [N_STEPS],
  input  logic [OPEN_W-1:0] open_a [N_STEPS],
  input  logic [SAMP_W-1:0] samp_a [N_STEPS],
  input  logic              conv_done,
  input  logic              last_smp,
  output logic              busy,
  output logic [STEP_W-1:0] cur_step,
  output logic [SEL_W-1:0]  mux_sel,
  output logic              conv_req,
  output logic              mask_clr,
  output logic              acc_clr,
  output logic              acc_add,
  output logic [AVG_W-1:0]  eff_avg
);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              first_ok, nxt_ok, ent_go;
  logic [STEP_W-1:0] first_idx, nxt_idx, ent_idx;

  assign busy     = (state_q != S_IDLE);
  assign cur_step = step_q;
  assign acc_add  = (state_q == S_CONV) && conv_done && mod_en;
  assign eff_avg  = (int'(avg_a[step_q]) > MAX_AVG) ? AVG_W'(MAX_AVG) : avg_a[step_q];

  // lowest enabled step overall, and lowest enabled step above the current one
  always_comb begin
    first_ok  = 1'b0;
    first_idx = '0;
    nxt_ok    = 1'b0;
    nxt_idx   = '0;
    for (int i = N_STEPS - 1; i >= 0; i--) begin
      if (mask[i+1]) begin
        first_ok  = 1'b1;
        first_idx = STEP_W'(i);
        if (i > int'(step_q)) begin
          nxt_ok  = 1'b1;
          nxt_idx = STEP_W'(i);
        end
      end
    end
  end

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    step_d   = step_q;
    mask_clr = 1'b0;
    acc_clr  = 1'b0;
    ent_go   = 1'b0;
    ent_idx  = first_idx;
    unique case (state_q)
      S_IDLE: begin
        if (start && mod_en && first_ok) ent_go = 1'b1;
      end
      S_OPEN: begin
        if (!mod_en) begin
          state_d = S_IDLE;
        end else if (cnt_q == CNT_W'(1)) begin
          if (samp_a[step_q] != '0) begin
            state_d = S_SAMP;
            cnt_d   = CNT_W'(samp_a[step_q]);
          end else begin
            state_d = S_CONV;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      S_SAMP: begin
        if (!mod_en)                   state_d = S_IDLE;
        else if (cnt_q == CNT_W'(1))   state_d = S_CONV;
        else                           cnt_d   = cnt_q - CNT_W'(1);
      end
      S_CONV: begin
        if (!mod_en) begin
          state_d = conv_done ? S_IDLE : S_DRAIN;
        end else if (conv_done) begin
          if (!last_smp) begin
            if (samp_a[step_q] != '0) begin
              state_d = S_SAMP;
              cnt_d   = CNT_W'(samp_a[step_q]);
            end else begin
              state_d = S_CONV;
            end
          end else if (nxt_ok) begin
            ent_go  = 1'b1;
            ent_idx = nxt_idx;
          end else if (cont_a[step_q] && first_ok) begin
            ent_go  = 1'b1;
          end else begin
            state_d  = S_IDLE;
            mask_clr = !cont_a[step_q];
          end
        end
      end
      S_DRAIN: begin
        if (conv_done) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase

    if (ent_go) begin
      step_d  = ent_idx;
      acc_clr = 1'b1;
      if (open_a[ent_idx] != '0) begin
        state_d = S_OPEN;
        cnt_d   = CNT_W'(open_a[ent_idx]);
      end else if (samp_a[ent_idx] != '0) begin
        state_d = S_SAMP;
        cnt_d   = CNT_W'(samp_a[ent_idx]);
      end else begin
        state_d = S_CONV;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      cnt_q    <= '0;
      step_q   <= '0;
      mux_sel  <= '0;
      conv_req <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      step_q   <= step_d;
      mux_sel  <= line_a[step_d];
      conv_req <= (state_d == S_CONV) || (state_d == S_DRAIN);
    end
  end

  // R9
  drain_req_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DRAIN) |-> conv_req);

  // R10
  idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |-> !conv_req);

  // R3
  mux_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_req && $past(conv_req) && !$past(conv_done)) |-> $stable(mux_sel));

  // R2
  no_charge_launch_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == S_IDLE) && (mask[MASK_W-1:1] == '0)) |=> (state_q == S_IDLE));

endmodule

// File: rtl/adc_step_seq.sv
module adc_step_seq
  import adc_seq_pkg::*;
#(
  parameter int N_STEPS = 16,
  parameter int N_LINES = 8,
  parameter int DATA_W  = 12,
  parameter int OPEN_W  = 18,
  parameter int SAMP_W  = 8,
  parameter int AVG_W   = 3,
  parameter int MAX_AVG = 4,
  localparam int STEP_W = $clog2(N_STEPS),
  localparam int SEL_W  = $clog2(N_LINES),
  localparam int MASK_W = N_STEPS + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              start,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic [SEL_W-1:0]  mux_sel,
  output logic              conv_req,
  output logic              res_valid,
  output logic [STEP_W-1:0] res_step,
  output logic [DATA_W-1:0] res_data
);

  logic              mod_en, mask_clr, busy, acc_clr, acc_add, last_smp;
  logic [MASK_W-1:0] mask;
  logic [STEP_W-1:0] cur_step;
  logic [AVG_W-1:0]  eff_avg;
  logic [SEL_W-1:0]  line_a [N_STEPS];
  logic [AVG_W-1:0]  avg_a  [N_STEPS];
  logic              cont_a [N_STEPS];
  logic [OPEN_W-1:0] open_a [N_STEPS];
  logic [SAMP_W-1:0] samp_a [N_STEPS];

  adc_seq_regs #(
    .N_STEPS(N_STEPS), .N_LINES(N_LINES), .OPEN_W(OPEN_W),
    .SAMP_W(SAMP_W), .AVG_W(AVG_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .mask_clr(mask_clr), .busy(busy), .cur_step(cur_step),
    .mod_en(mod_en), .mask(mask), .line_a(line_a), .avg_a(avg_a),
    .cont_a(cont_a), .open_a(open_a), .samp_a(samp_a)
  );

  adc_seq_ctl #(
    .N_STEPS(N_STEPS), .N_LINES(N_LINES), .OPEN_W(OPEN_W),
    .SAMP_W(SAMP_W), .AVG_W(AVG_W), .MAX_AVG(MAX_AVG)
  ) u_ctl (
    .clk(clk), .rst(rst), .mod_en(mod_en), .start(start), .mask(mask),
    .line_a(line_a), .avg_a(avg_a), .cont_a(cont_a), .open_a(open_a),
    .samp_a(samp_a), .conv_done(conv_done), .last_smp(last_smp),
    .busy(busy), .cur_step(cur_step), .mux_sel(mux_sel), .conv_req(conv_req),
    .mask_clr(mask_clr), .acc_clr(acc_clr), .acc_add(acc_add), .eff_avg(eff_avg)
  );

  adc_seq_acc #(
    .DATA_W(DATA_W), .AVG_W(AVG_W), .MAX_AVG(MAX_AVG), .STEP_W(STEP_W)
  ) u_acc (
    .clk(clk), .rst(rst), .clr(acc_clr), .add(acc_add), .data(conv_data),
    .avg(eff_avg), .step(cur_step), .last(last_smp), .res_valid(res_valid),
    .res_step(res_step), .res_data(res_data)
  );

endmodule

// File: tb/adc_step_seq_tb.sv
module adc_step_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        start = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic [2:0]  mux_sel;
  logic        conv_req, res_valid;
  logic [3:0]  res_step;
  logic [11:0] res_data;

  always #2.5 clk = ~clk;

  adc_step_seq u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .start(start),
    .conv_done(conv_done), .conv_data(conv_data), .mux_sel(mux_sel),
    .conv_req(conv_req), .res_valid(res_valid), .res_step(res_step),
    .res_data(res_data)
  );

  int checks = 0, errors = 0, rcount = 0;
  int unsigned smp_k = 0;
  int stub_cnt = 0;
  bit req_seen = 0, finished = 0;
  int exp_line[$], exp_step[$], exp_data[$];
  int cfg_line[16], cfg_avg[16], cfg_cont[16], cfg_open[16], cfg_samp[16];

  function automatic logic [11:0] gen(input int unsigned k);
    logic [31:0] h;
    h = k * 32'd2654435761 + 32'h5a5a;
    return h[19:8];
  endfunction

  function automatic int clampa(input int a);
    return (a > 4) ? 4 : a;
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // converter stub (latency 4) and result monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (conv_req) req_seen = 1;
      conv_done = 1'b0;
      if (stub_cnt > 0) begin
        stub_cnt--;
        if (stub_cnt == 0) begin
          conv_done = 1'b1;
          conv_data = gen(smp_k);
          smp_k++;
          if (exp_line.size() > 0) chk("R3 mux_sel at conversion", int'(mux_sel), exp_line.pop_front());
        end
      end else if (conv_req) begin
        stub_cnt = 4;
      end
      if (res_valid) begin
        rcount++;
        if (exp_step.size() == 0) chk("R6 unexpected result", 1, 0);
        else begin
          chk("R6 result step tag", int'(res_step), exp_step.pop_front());
          chk("R5 averaged data", int'(res_data), exp_data.pop_front());
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output int v);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    v = int'(cfg_rdata);
  endtask

  task automatic prog(input int s, input int ln, input int av, input int ct, input int op, input int sp);
    cfg_line[s] = ln; cfg_avg[s] = av; cfg_cont[s] = ct; cfg_open[s] = op; cfg_samp[s] = sp;
    wr(6'h10 + 6'(s), (32'(ct) << 8) | (32'(av) << 4) | 32'(ln));
    wr(6'h20 + 6'(s), (32'(sp) << 24) | 32'(op));
  endtask

  task automatic build(input int m, input int passes);
    int unsigned k;
    k = smp_k;
    for (int p = 0; p < passes; p++)
      for (int s = 0; s < 16; s++)
        if (m[s+1]) begin
          int n, sum;
          n = 1 << clampa(cfg_avg[s]);
          sum = 0;
          for (int j = 0; j < n; j++) begin
            exp_line.push_back(cfg_line[s]);
            sum += int'(gen(k));
            k++;
          end
          exp_step.push_back(s);
          exp_data.push_back((sum >> clampa(cfg_avg[s])) & 'hFFF);
        end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_drain();
    int g = 0;
    while (exp_step.size() != 0 && g < 20000) begin @(negedge clk); g++; end
  endtask

  task automatic run_oneshot(input int m);
    int v;
    build(m, 1);
    wr(6'h01, 32'(m));
    pulse_start();
    wait_drain();
    repeat (3) @(negedge clk);
    chk("R7 one-shot results all delivered", exp_step.size(), 0);
    rd(6'h01, v); chk("R7 mask cleared after pass", v, 0);
    rd(6'h02, v); chk("R10 status idle", v, 'h10);
  endtask

  initial begin
    int v, n;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset conv_req", int'(conv_req), 0);
    chk("reset res_valid", int'(res_valid), 0);
    rd(6'h02, v); chk("R10 reset status", v, 'h10);
    rd(6'h01, v); chk("R1 reset mask", v, 0);

    // R1 readback
    prog(9, 5, 3, 1, 'h3FFFF, 'hFF);
    rd(6'h19, v); chk("R1 step config readback", v, 'h135);
    rd(6'h29, v); chk("R1 step delay readback", v, 'hFF03FFFF);
    prog(9, 0, 0, 0, 0, 0);
    wr(6'h00, 1);
    rd(6'h00, v); chk("R1 enable readback", v, 1);

    // R4 delay timing, open 5 sample 3
    prog(4, 6, 0, 0, 5, 3);
    build(1 << 5, 1);
    wr(6'h01, 1 << 5);
    @(negedge clk); start = 1'b1;
    n = 0;
    do begin @(negedge clk); start = 1'b0; n++; end while (!conv_req && n < 200);
    chk("R4 request after open+sample", n, 9);
    wait_drain();
    // R4 zero delays
    prog(4, 6, 0, 0, 0, 0);
    build(1 << 5, 1);
    wr(6'h01, 1 << 5);
    @(negedge clk); start = 1'b1;
    n = 0;
    do begin @(negedge clk); start = 1'b0; n++; end while (!conv_req && n < 200);
    chk("R4 zero delay means no wait", n, 1);
    wait_drain();

    // R5 averaging code above the maximum behaves as 16 samples
    prog(7, 5, 6, 0, 1, 1);
    run_oneshot(1 << 8);
    prog(7, 0, 0, 0, 0, 0);

    // R3 scan order with a gap, mixed averaging
    prog(1, 2, 1, 0, 2, 0);
    prog(3, 7, 2, 0, 0, 2);
    prog(12, 1, 0, 0, 3, 1);
    run_oneshot((1 << 2) | (1 << 4) | (1 << 13));

    // R2 charge bit alone starts nothing
    wr(6'h01, 1);
    req_seen = 0;
    pulse_start();
    repeat (20) @(negedge clk);
    chk("R2 charge bit launches nothing", int'(req_seen), 0);
    rd(6'h02, v); chk("R2 status stays idle", v, 'h10);
    // R2 start ignored while disabled
    wr(6'h00, 0);
    wr(6'h01, 1 << 2);
    req_seen = 0;
    pulse_start();
    repeat (20) @(negedge clk);
    chk("R2 start ignored when disabled", int'(req_seen), 0);
    wr(6'h00, 1);
    wr(6'h01, 0);

    // R8 continuous wrap
    prog(2, 3, 0, 0, 1, 0);
    prog(5, 4, 1, 1, 0, 1);
    build((1 << 3) | (1 << 6), 4);
    rcount = 0;
    wr(6'h01, (1 << 3) | (1 << 6));
    pulse_start();
    n = 0;
    while (rcount < 5 && n < 5000) begin @(negedge clk); n++; end
    wr(6'h00, 0);
    repeat (40) @(negedge clk);
    chk("R8 continuous wrapped without start", int'(rcount >= 5), 1);
    rd(6'h01, v); chk("R8 mask kept in continuous mode", v, (1 << 3) | (1 << 6));
    exp_line.delete(); exp_step.delete(); exp_data.delete();
    wr(6'h01, 0);
    wr(6'h00, 1);
    prog(5, 4, 1, 0, 0, 1);

    // R9 / R10 disable during open delay
    prog(3, 1, 0, 0, 60, 0);
    wr(6'h01, 1 << 4);
    pulse_start();
    rd(6'h02, v); chk("R10 busy status shows step", v, 'h23);
    wr(6'h00, 0);
    req_seen = 0;
    repeat (70) @(negedge clk);
    chk("R9 no request after disable in delay", int'(req_seen), 0);
    rd(6'h02, v); chk("R9 idle after disable in delay", v, 'h10);
    wr(6'h00, 1);
    prog(3, 1, 0, 0, 0, 0);

    // R9 disable during a conversion
    prog(0, 2, 0, 0, 0, 0);
    wr(6'h01, 1 << 1);
    @(negedge clk); start = 1'b1;
    n = 0;
    do begin @(negedge clk); start = 1'b0; n++; end while (!conv_req && n < 200);
    rcount = 0;
    wr(6'h00, 0);
    chk("R9 request held through disable", int'(conv_req), 1);
    repeat (10) @(negedge clk);
    chk("R9 request dropped after done", int'(conv_req), 0);
    chk("R9 sample discarded", rcount, 0);
    rd(6'h02, v); chk("R9 idle after drain", v, 'h10);
    wr(6'h01, 0);
    wr(6'h00, 1);

    // random one-shot scenarios
    for (int t = 0; t < 6; t++) begin
      int m;
      for (int s = 0; s < 16; s++)
        prog(s, int'($urandom % 8), ($urandom % 4 == 0) ? int'(5 + $urandom % 3) : int'($urandom % 4),
             0, int'($urandom % 4), int'($urandom % 3));
      m = int'(($urandom & 32'h1FFFE) | (32'h1 << (1 + $urandom % 16)));
      run_oneshot(m);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule